// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timing Generator

This block drives the select, write and read strobes of an 8080-style parallel display bus for one chip-select channel. The edges are not fixed. Each strobe's assert and release tick, the write and read cycle lengths, the read sampling tick and a minimum chip-select gap all come from tick counts held in configuration. A granularity bit sets the tick to one or two clocks.

A single-clock start, together with a read/write flag and a command/data flag, launches one access. All timing settings are taken in at that moment. Settings that break the edge-ordering rules are clamped to the nearest legal value, so strobe edges never overlap.

A write drives the data bus for the whole access. A read samples the input bus at the access tick and returns the word when the access ends. A one-clock done pulse closes each access, and a new start is accepted in that same clock. Each strobe and the command/data line can have its polarity inverted.

Top module: `pbus_strobe_gen`

## Requirements
- R1: After reset, done is 0, bus_oe is 0, and cs_o, we_o and re_o sit at their inactive levels.
- R2: In a write access (rd_nwr=0), tick t runs from 0. Select is active for cs_on <= t < cs_off_eff and write-enable for we_on <= t < we_off_eff. Read-enable stays inactive. bus_oe is 1 and bus_out equals wr_data on every clock of the access.
- R3: In a read access (rd_nwr=1), read-enable is active for re_on <= t < re_off_eff. Write-enable stays inactive and bus_oe stays 0.
- R4: With gran=0 a tick is one clock. With gran=1 a tick is two clocks, so every edge position and the access length double in clocks.
- R5: Each release tick is clamped up to its assert tick + 1 when it is not greater: we_off_eff, re_off_eff and the select release. cs_off_eff is then raised to at least max(we_off_eff, re_off_eff).
- R6: An access lasts max(cycle_eff, cs_off_eff + cs_gap) ticks. For writes, cycle_eff = max(wr_cycle, we_off_eff). For reads, cycle_eff = max(rd_cycle, re_off_eff, acc_eff). No strobe is active in the done clock.
- R7: acc_eff is acc_time, or re_on + 1 when acc_time <= re_on. rd_data holds the rd_bus value present at the clock edge that ends tick acc_eff - 1, and it is valid from the done clock onward.
- R8: done is high for exactly one clock, the clock right after the last tick. A start in that clock launches the next access with no idle clock between them.
- R9: A start that arrives while an access is in progress is ignored and does not change the running access.
- R10: A polarity bit of 1 makes its strobe active-high; a polarity bit of 0 makes it active-low. pol_cs, pol_we and pol_re act independently.
- R11: a0_o equals data_sel XOR pol_a0 as sampled at start, with data_sel 0 for a command and 1 for data. It stays stable through the access and is held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one access when idle |
| rd_nwr | input | 1 | 1 read, 0 write |
| data_sel | input | 1 | 0 command, 1 data/parameter |
| gran | input | 1 | Tick length: 0 one clock, 1 two clocks |
| pol_cs | input | 1 | Select polarity, 1 active-high |
| pol_we | input | 1 | Write strobe polarity, 1 active-high |
| pol_re | input | 1 | Read strobe polarity, 1 active-high |
| pol_a0 | input | 1 | Invert command/data line |
| cs_on | input | 4 | Select assert tick |
| cs_off | input | 6 | Select release tick |
| we_on | input | 4 | Write strobe assert tick |
| we_off | input | 6 | Write strobe release tick |
| re_on | input | 4 | Read strobe assert tick |
| re_off | input | 6 | Read strobe release tick |
| wr_cycle | input | 6 | Write cycle length in ticks |
| rd_cycle | input | 6 | Read cycle length in ticks |
| acc_time | input | 6 | Read sampling tick |
| cs_gap | input | 6 | Minimum ticks between select release and access end |
| wr_data | input | DATA_W | Write word |
| rd_bus | input | DATA_W | Bus value seen during reads |
| cs_o | output | 1 | Select strobe pin |
| we_o | output | 1 | Write strobe pin |
| re_o | output | 1 | Read strobe pin |
| a0_o | output | 1 | Command/data select pin |
| bus_out | output | DATA_W | Driven write word |
| bus_oe | output | 1 | Bus drive enable |
| rd_data | output | DATA_W | Sampled read word |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The end of one access and the acceptance of the next can fall in the same clock. The done pulse and a start that the block must take are both present in that clock. The bench provokes this by raising start right after it sees done, then switching from a write to a read. It judges the result by requiring that the second access's trace begins on the very next clock, with that access's own strobe windows, length and sampled word, and that done never lasts two clocks. A start raised in the middle of a long access is also checked: the running access's length and windows must be unchanged.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  parameter int ON_W  = 4;
  parameter int OFF_W = 6;
  localparam int END_W = OFF_W + 1;
  localparam int NUM_STROBES = 3;

  // Clamped edge set for one access, all ticks widened to OFF_W
  typedef struct packed {
    logic [OFF_W-1:0] cs_on;
    logic [OFF_W-1:0] cs_off;
    logic [OFF_W-1:0] we_on;
    logic [OFF_W-1:0] we_off;
    logic [OFF_W-1:0] re_on;
    logic [OFF_W-1:0] re_off;
    logic [OFF_W-1:0] acc;
    logic [END_W-1:0] last;
  } edge_set_t;
endpackage

// File: rtl/pbus_edge_clamp.sv
module pbus_edge_clamp
  import pbus_pkg::*;
(
  input  logic [ON_W-1:0]  cs_on_i,
  input  logic [OFF_W-1:0] cs_off_i,
  input  logic [ON_W-1:0]  we_on_i,
  input  logic [OFF_W-1:0] we_off_i,
  input  logic [ON_W-1:0]  re_on_i,
  input  logic [OFF_W-1:0] re_off_i,
  input  logic [OFF_W-1:0] wr_cyc_i,
  input  logic [OFF_W-1:0] rd_cyc_i,
  input  logic [OFF_W-1:0] acc_i,
  input  logic [OFF_W-1:0] gap_i,
  input  logic             rd_i,
  output edge_set_t        set_o
);
  localparam int PAD_W = OFF_W - ON_W;

  function automatic logic [OFF_W-1:0] widen(input logic [ON_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  // release must lie strictly after assert
  function automatic logic [OFF_W-1:0] after(input logic [OFF_W-1:0] on,
                                             input logic [OFF_W-1:0] off);
    return (off > on) ? off : on + 1'b1;
  endfunction

  function automatic logic [OFF_W-1:0] mx(input logic [OFF_W-1:0] a,
                                          input logic [OFF_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [OFF_W-1:0] cs_on_w, we_on_w, re_on_w;
  logic [OFF_W-1:0] we_off_e, re_off_e, cs_off_a, cs_off_e, acc_e;
  logic [OFF_W-1:0] cyc_w, cyc_r, cyc_sel;
  logic [END_W-1:0] gap_end, end_t;

  always_comb begin
    cs_on_w  = widen(cs_on_i);
    we_on_w  = widen(we_on_i);
    re_on_w  = widen(re_on_i);
    we_off_e = after(we_on_w, we_off_i);
    re_off_e = after(re_on_w, re_off_i);
    cs_off_a = after(cs_on_w, cs_off_i);
    cs_off_e = mx(cs_off_a, mx(we_off_e, re_off_e));
    acc_e    = after(re_on_w, acc_i);
    cyc_w    = mx(wr_cyc_i, we_off_e);
    cyc_r    = mx(rd_cyc_i, mx(re_off_e, acc_e));
    cyc_sel  = rd_i ? cyc_r : cyc_w;
    gap_end  = {1'b0, cs_off_e} + {1'b0, gap_i};
    end_t    = ({1'b0, cyc_sel} > gap_end) ? {1'b0, cyc_sel} : gap_end;

    set_o.cs_on  = cs_on_w;
    set_o.cs_off = cs_off_e;
    set_o.we_on  = we_on_w;
    set_o.we_off = we_off_e;
    set_o.re_on  = re_on_w;
    set_o.re_off = re_off_e;
    set_o.acc    = acc_e;
    set_o.last   = end_t - 1'b1;
  end
endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic slow_i,
  output logic adv_o
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d  = run_i & slow_i & ~ph_q;
    adv_o = run_i & (~slow_i | ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/pbus_access_seq.sv
module pbus_access_seq
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              a0_i,
  input  logic              slow_i,
  input  logic              adv_i,
  input  edge_set_t         set_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rbus_i,
  output logic              run_o,
  output logic              slow_o,
  output logic              cs_act_o,
  output logic              we_act_o,
  output logic              re_act_o,
  output logic              oe_o,
  output logic              a0_o,
  output logic              done_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;
  localparam logic [END_W-1:0] TICK_ONE = END_W'(1);

  st_t              st_q, st_d;
  edge_set_t        set_q;
  logic             rd_q, a0_q, slow_q, done_q, done_d;
  logic [END_W-1:0] tick_q, tick_d;
  logic [DATA_W-1:0] wd_q, rdat_q;
  logic             load_en, tick_en, cap_en, at_last, running;

  function automatic logic in_win(input logic [END_W-1:0] t,
                                  input logic [OFF_W-1:0] on,
                                  input logic [OFF_W-1:0] off);
    return (t >= {1'b0, on}) && (t < {1'b0, off});
  endfunction

  // next-state
  always_comb begin
    running = (st_q == ST_RUN);
    load_en = (st_q == ST_IDLE) && start_i;
    tick_en = running && adv_i;
    at_last = (tick_q == set_q.last);
    cap_en  = tick_en && rd_q && ((tick_q + TICK_ONE) == {1'b0, set_q.acc});
    st_d    = st_q;
    tick_d  = tick_q;
    done_d  = 1'b0;
    if (load_en) begin
      st_d   = ST_RUN;
      tick_d = '0;
    end else if (tick_en) begin
      if (at_last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        tick_d = tick_q + TICK_ONE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tick_q <= '0;
      done_q <= 1'b0;
      set_q  <= '0;
      rd_q   <= 1'b0;
      a0_q   <= 1'b0;
      slow_q <= 1'b0;
      wd_q   <= '0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      tick_q <= tick_d;
      done_q <= done_d;
      if (load_en) begin
        set_q  <= set_i;
        rd_q   <= rd_i;
        a0_q   <= a0_i;
        slow_q <= slow_i;
        wd_q   <= wdata_i;
      end
      if (cap_en) rdat_q <= rbus_i;
    end
  end

  always_comb begin
    run_o    = running;
    slow_o   = slow_q;
    cs_act_o = running && in_win(tick_q, set_q.cs_on, set_q.cs_off);
    we_act_o = running && !rd_q && in_win(tick_q, set_q.we_on, set_q.we_off);
    re_act_o = running &&  rd_q && in_win(tick_q, set_q.re_on, set_q.re_off);
    oe_o     = running && !rd_q;
    a0_o     = a0_q;
    done_o   = done_q;
    wdata_o  = wd_q;
    rdata_o  = rdat_q;
  end
endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic              data_sel,
  input  logic              gran,
  input  logic              pol_cs,
  input  logic              pol_we,
  input  logic              pol_re,
  input  logic              pol_a0,
  input  logic [ON_W-1:0]   cs_on,
  input  logic [OFF_W-1:0]  cs_off,
  input  logic [ON_W-1:0]   we_on,
  input  logic [OFF_W-1:0]  we_off,
  input  logic [ON_W-1:0]   re_on,
  input  logic [OFF_W-1:0]  re_off,
  input  logic [OFF_W-1:0]  wr_cycle,
  input  logic [OFF_W-1:0]  rd_cycle,
  input  logic [OFF_W-1:0]  acc_time,
  input  logic [OFF_W-1:0]  cs_gap,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_bus,
  output logic              cs_o,
  output logic              we_o,
  output logic              re_o,
  output logic              a0_o,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  edge_set_t set_w;
  logic run_w, slow_w, adv_w, a0_lvl;
  logic [NUM_STROBES-1:0] act_vec, pol_vec, pin_vec;

  pbus_edge_clamp u_clamp (
    .cs_on_i (cs_on),    .cs_off_i(cs_off),
    .we_on_i (we_on),    .we_off_i(we_off),
    .re_on_i (re_on),    .re_off_i(re_off),
    .wr_cyc_i(wr_cycle), .rd_cyc_i(rd_cycle),
    .acc_i   (acc_time), .gap_i   (cs_gap),
    .rd_i    (rd_nwr),   .set_o   (set_w)
  );

  pbus_tick_div u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .slow_i(slow_w), .adv_o(adv_w)
  );

  pbus_access_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (clk),       .rst_n   (rst_n),
    .start_i (start),     .rd_i    (rd_nwr),
    .a0_i    (data_sel),  .slow_i  (gran),
    .adv_i   (adv_w),     .set_i   (set_w),
    .wdata_i (wr_data),   .rbus_i  (rd_bus),
    .run_o   (run_w),     .slow_o  (slow_w),
    .cs_act_o(act_vec[0]), .we_act_o(act_vec[1]), .re_act_o(act_vec[2]),
    .oe_o    (bus_oe),    .a0_o    (a0_lvl),
    .done_o  (done),      .wdata_o (bus_out),
    .rdata_o (rd_data)
  );

  assign pol_vec = {pol_re, pol_we, pol_cs};

  // per-strobe polarity stage: pol 1 drives the active state high
  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_pol
    assign pin_vec[g] = pol_vec[g] ? act_vec[g] : ~act_vec[g];
  end

  assign cs_o = pin_vec[0];
  assign we_o = pin_vec[1];
  assign re_o = pin_vec[2];
  assign a0_o = a0_lvl ^ pol_a0;
endmodule

// File: rtl/pbus_strobe_chk.sv
module pbus_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic pol_cs,
  input logic pol_we,
  input logic pol_re,
  input logic pol_a0,
  input logic cs_o,
  input logic we_o,
  input logic re_o,
  input logic a0_o,
  input logic bus_oe,
  input logic done
);
  logic cs_on_w, we_on_w, re_on_w;
  assign cs_on_w = (cs_o == pol_cs);
  assign we_on_w = (we_o == pol_we);
  assign re_on_w = (re_o == pol_re);

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_NO_WE_WITH_RE: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_on_w && re_on_w)); // R3
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    re_on_w |-> !bus_oe); // R3
  AST_IDLE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cs_on_w && !we_on_w && !re_on_w && !bus_oe)); // R6
  AST_A0_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on_w && $past(cs_on_w) && $stable(pol_a0) && $stable(pol_cs)) |-> $stable(a0_o)); // R11
endmodule

bind pbus_strobe_gen pbus_strobe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pol_cs(pol_cs), .pol_we(pol_we), .pol_re(pol_re),
  .pol_a0(pol_a0), .cs_o(cs_o), .we_o(we_o), .re_o(re_o), .a0_o(a0_o),
  .bus_oe(bus_oe), .done(done)
);

// File: tb/pbus_strobe_gen_tb.sv
module pbus_strobe_gen_tb_top;
  localparam int SEED = 64;

  typedef struct {
    int cs_on, cs_off, we_on, we_off, re_on, re_off;
    int wr_cyc, rd_cyc, acc, gap;
    bit gran, pcs, pwe, pre, pa0;
  } cfg_t;

  typedef struct {
    string tag;
    int total, cs_first, cs_len, we_first, we_len, re_first, re_len, oe_len, a0;
    bit chk_rd;
    int rd;
  } exp_t;

  logic clk, rst_n, start, rd_nwr, data_sel, gran;
  logic pol_cs, pol_we, pol_re, pol_a0;
  logic [3:0] cs_on, we_on, re_on;
  logic [5:0] cs_off, we_off, re_off, wr_cycle, rd_cycle, acc_time, cs_gap;
  logic [7:0] wr_data, rd_bus, bus_out, rd_data;
  logic cs_o, we_o, re_o, a0_o, bus_oe, done;

  int n_chk, n_bad, cyc;
  bit finished;
  exp_t exp_q[$];

  pbus_strobe_gen #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .data_sel(data_sel),
    .gran(gran), .pol_cs(pol_cs), .pol_we(pol_we), .pol_re(pol_re), .pol_a0(pol_a0),
    .cs_on(cs_on), .cs_off(cs_off), .we_on(we_on), .we_off(we_off),
    .re_on(re_on), .re_off(re_off), .wr_cycle(wr_cycle), .rd_cycle(rd_cycle),
    .acc_time(acc_time), .cs_gap(cs_gap), .wr_data(wr_data), .rd_bus(rd_bus),
    .cs_o(cs_o), .we_o(we_o), .re_o(re_o), .a0_o(a0_o), .bus_out(bus_out),
    .bus_oe(bus_oe), .rd_data(rd_data), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected trace derived from the requirements
  function automatic exp_t predict(input cfg_t c, input bit rd, input bit dat, input string tag);
    exp_t e;
    int k, weoff, reoff, csoff, acc, cycv, endt;
    k     = c.gran ? 2 : 1;                                   // R4
    weoff = (c.we_off > c.we_on) ? c.we_off : c.we_on + 1;    // R5
    reoff = (c.re_off > c.re_on) ? c.re_off : c.re_on + 1;
    csoff = (c.cs_off > c.cs_on) ? c.cs_off : c.cs_on + 1;
    csoff = mx(csoff, mx(weoff, reoff));
    acc   = (c.acc > c.re_on) ? c.acc : c.re_on + 1;          // R7
    cycv  = rd ? mx(c.rd_cyc, mx(reoff, acc)) : mx(c.wr_cyc, weoff);
    endt  = mx(cycv, csoff + c.gap);                          // R6
    e.tag      = tag;
    e.total    = endt * k;
    e.cs_first = c.cs_on * k;
    e.cs_len   = (csoff - c.cs_on) * k;
    e.we_first = rd ? -1 : c.we_on * k;
    e.we_len   = rd ? 0 : (weoff - c.we_on) * k;
    e.re_first = rd ? c.re_on * k : -1;
    e.re_len   = rd ? (reoff - c.re_on) * k : 0;
    e.oe_len   = rd ? 0 : e.total;
    e.a0       = dat;
    e.chk_rd   = rd;
    e.rd       = (SEED + acc * k - 1) % 256;
    return e;
  endfunction

  function automatic cfg_t base_cfg();
    cfg_t c;
    c.cs_on = 1; c.cs_off = 8; c.we_on = 2; c.we_off = 6; c.re_on = 1; c.re_off = 3;
    c.wr_cyc = 10; c.rd_cyc = 7; c.acc = 4; c.gap = 0;
    c.gran = 0; c.pcs = 0; c.pwe = 0; c.pre = 0; c.pa0 = 0;
    return c;
  endfunction

  // driver: called at a falling edge
  task automatic launch(input cfg_t c, input bit rd, input bit dat,
                        input logic [7:0] wd, input string tag);
    #1;
    cs_on = 4'(c.cs_on); cs_off = 6'(c.cs_off); we_on = 4'(c.we_on); we_off = 6'(c.we_off);
    re_on = 4'(c.re_on); re_off = 6'(c.re_off); wr_cycle = 6'(c.wr_cyc); rd_cycle = 6'(c.rd_cyc);
    acc_time = 6'(c.acc); cs_gap = 6'(c.gap); gran = c.gran;
    pol_cs = c.pcs; pol_we = c.pwe; pol_re = c.pre; pol_a0 = c.pa0;
    rd_nwr = rd; data_sel = dat; wr_data = wd;
    exp_q.push_back(predict(c, rd, dat, tag));
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // monitor
  initial begin
    bit inacc, a0bad, dbad, prev_done;
    int c, csf, csl, wef, wel, rf, rl, oel, a0v;
    exp_t e;
    inacc = 0; prev_done = 0; rd_bus = 8'h00;
    c = 0; csf = -1; csl = 0; wef = -1; wel = 0; rf = -1; rl = 0; oel = 0; a0v = 0;
    a0bad = 0; dbad = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_done) chk(!done, "R8", "done width", int'(done), 0);
        prev_done = done;
        if (inacc && done) begin
          inacc = 0;
          if (exp_q.size() == 0) begin
            chk(0, "R8", "unexpected access end", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(c == e.total, "R6", {e.tag, " length"}, c, e.total);
            chk(csf == e.cs_first && csl == e.cs_len, "R2", {e.tag, " select window"},
                csf * 1000 + csl, e.cs_first * 1000 + e.cs_len);
            chk(wef == e.we_first && wel == e.we_len, "R2", {e.tag, " write window"},
                wef * 1000 + wel, e.we_first * 1000 + e.we_len);
            chk(rf == e.re_first && rl == e.re_len, "R3", {e.tag, " read window"},
                rf * 1000 + rl, e.re_first * 1000 + e.re_len);
            chk(oel == e.oe_len && !dbad, "R2", {e.tag, " bus drive"}, oel, e.oe_len);
            chk(a0v == e.a0 && !a0bad, "R11", {e.tag, " a0 level"}, a0v, e.a0);
            if (e.chk_rd) chk(int'(rd_data) == e.rd, "R7", {e.tag, " read word"}, int'(rd_data), e.rd);
          end
        end
        if (!inacc && start) begin
          inacc = 1; c = 0; csf = -1; csl = 0; wef = -1; wel = 0; rf = -1; rl = 0;
          oel = 0; a0bad = 0; dbad = 0;
        end
        if (inacc) begin
          if (cs_o == pol_cs) begin if (csf < 0) csf = c; csl++; end
          if (we_o == pol_we) begin if (wef < 0) wef = c; wel++; end
          if (re_o == pol_re) begin if (rf < 0) rf = c; rl++; end
          if (bus_oe) begin oel++; if (bus_out != wr_data) dbad = 1; end
          if (c == 0) a0v = int'(a0_o ^ pol_a0);
          else if (int'(a0_o ^ pol_a0) != a0v) a0bad = 1;
          rd_bus = 8'((SEED + c) % 256);
          c++;
        end else begin
          rd_bus = 8'h00;
        end
      end
    end
  end

  // watchdog
  initial begin
    cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cfg_t c;
    finished = 0; n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 0; rd_nwr = 0; data_sel = 0; gran = 0;
    pol_cs = 0; pol_we = 0; pol_re = 0; pol_a0 = 0;
    cs_on = 0; cs_off = 0; we_on = 0; we_off = 0; re_on = 0; re_off = 0;
    wr_cycle = 0; rd_cycle = 0; acc_time = 0; cs_gap = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle levels after reset (active-low strobes)
    chk(cs_o && we_o && re_o, "R1", "strobe idle", int'({cs_o, we_o, re_o}), 7);
    chk(!done && !bus_oe, "R1", "done/oe idle", int'({done, bus_oe}), 0);

    c = base_cfg();
    launch(c, 0, 0, 8'h5A, "R2 write"); wait_done(); repeat (2) @(negedge clk);
    launch(c, 1, 1, 8'h00, "R3 read");  wait_done(); repeat (2) @(negedge clk);

    c.gran = 1; c.gap = 4;  // R4 doubled ticks, gap extends the end
    launch(c, 0, 1, 8'hC3, "R4 write"); wait_done(); repeat (2) @(negedge clk);
    launch(c, 1, 0, 8'h00, "R4 read");  wait_done(); repeat (2) @(negedge clk);

    c = base_cfg();  // R5 clamps
    c.we_on = 5; c.we_off = 3; c.cs_on = 4; c.cs_off = 2; c.re_on = 1; c.re_off = 0;
    c.wr_cyc = 0; c.gap = 3;
    launch(c, 0, 0, 8'h11, "R5 clamp"); wait_done(); repeat (2) @(negedge clk);

    c = base_cfg();  // R7 sampling tick clamped above re_on
    c.re_on = 4; c.re_off = 9; c.acc = 0; c.rd_cyc = 2; c.cs_on = 0; c.cs_off = 3;
    c.we_on = 0; c.we_off = 1;
    launch(c, 1, 1, 8'h00, "R7 acc clamp"); wait_done(); repeat (2) @(negedge clk);

    c.re_on = 1; c.re_off = 3; c.acc = 12; c.rd_cyc = 4;  // R7 sample past cycle
    launch(c, 1, 0, 8'h00, "R7 late sample"); wait_done(); repeat (2) @(negedge clk);
    c.gran = 1;
    launch(c, 1, 0, 8'h00, "R7 late sample slow"); wait_done(); repeat (2) @(negedge clk);

    c = base_cfg();  // R10 all active-high, data select inverted
    c.pcs = 1; c.pwe = 1; c.pre = 1; c.pa0 = 1;
    launch(c, 0, 1, 8'h77, "R10 pol high"); wait_done(); repeat (2) @(negedge clk);
    c.pwe = 0;
    launch(c, 1, 0, 8'h00, "R10 pol mixed"); wait_done(); repeat (2) @(negedge clk);

    c = base_cfg();  // R8 start in the done clock
    launch(c, 0, 0, 8'h24, "R8 first"); wait_done();
    c.re_on = 2; c.re_off = 5; c.acc = 3;
    launch(c, 1, 1, 8'h00, "R8 second"); wait_done(); repeat (2) @(negedge clk);

    c = base_cfg();  // R9 start during a long access
    c.wr_cyc = 40;
    launch(c, 0, 1, 8'h99, "R9 busy start");
    repeat (3) @(negedge clk);
    #1; start = 1'b1; rd_nwr = 1'b1; data_sel = 1'b0;
    @(negedge clk); #1; start = 1'b0;
    wait_done(); repeat (2) @(negedge clk);

    c = base_cfg();  // largest counts with slow ticks
    c.cs_off = 63; c.wr_cyc = 63; c.gap = 63; c.gran = 1;
    launch(c, 0, 0, 8'hE1, "R6 max"); wait_done(); repeat (2) @(negedge clk);

    chk(exp_q.size() == 0, "R6", "pending items", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule